// File: doc/BRIEF.md
# Serial Shift Register with Transparent Storage and Cascade Taps

This block takes serial data, one bit per rising edge of a serial clock, through a chain of stages. A strobe copies the chain into a storage bank that drives a parallel output. While strobe is high, the storage bank is transparent and follows the chain on every clock. While strobe is low, it holds its contents.

The parallel output is a data bus plus a per-bit drive-enable vector. A wrapper at the pad level turns that pair into a three-state bus. The block also has two serial cascade taps, both carrying the last stage. The early tap changes with the rising serial edge. The late tap is re-timed to the falling serial edge, so a downstream copy clocked from a slow-edged serial clock still samples a settled bit.

All logic runs on one fast system clock. The serial clock is an ordinary input, and its edges are detected by comparing it with its value at the previous system-clock edge. Each level of the serial clock must stay stable for at least one system-clock cycle.

Top module: `shift_store_reg`

## Requirements
- R1: A synchronous active-high `rst` clears every chain stage, the storage bank, both cascade taps and the drive-enable vector to zero at the next `clk` edge.
- R2: On the first `clk` edge at which `sclk` is seen high after being low (a serial rise), stage 0 takes `sdata` and each stage i takes the old value of stage i-1. Bit 0 of `par_q` is stage 0.
- R3: At every `clk` edge where `strobe` is high, the storage bank takes the chain value after that edge. This includes a serial rise in the same cycle, in which case the storage takes the post-shift value.
- R4: At a `clk` edge where `strobe` is low, the storage bank keeps its previous contents, whatever the chain does.
- R5: `par_q` presents the storage bank. `par_en` becomes all ones one `clk` edge after `oe` is sampled high, and all zeros one edge after `oe` is sampled low.
- R6: After each serial rise, `casc_early` equals the new value of the last stage. This is the old value of the next-to-last stage.
- R7: `casc_late` takes the last stage's value at a serial fall (the first `clk` edge with `sclk` low after high) and holds it at every other edge.
- R8: `oe` has no effect on shifting, on the storage bank or on either cascade tap.
- R9: When two copies share `sclk` and `strobe`, and the second copy's `sdata` is fed from the first copy's `casc_late`, they form one 2*STAGES chain. After 16 bits and a strobe, the first copy holds the 8 most recent bits and the second holds the 8 before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial shift clock, sampled by `clk` |
| sdata | input | 1 | Serial data in |
| strobe | input | 1 | Storage transparency control |
| oe | input | 1 | Parallel drive enable request |
| par_q | output | STAGES | Storage bank contents |
| par_en | output | STAGES | Per-bit drive enable for the parallel bus |
| casc_early | output | 1 | Last stage, updated on the serial rise |
| casc_late | output | 1 | Last stage, re-timed on the serial fall |

## Verification
A shift and a storage load can fall in the same system-clock cycle. The bench provokes this by raising `sclk` and `strobe` together at one falling `clk` edge, then dropping `strobe` before the next serial pulse. It judges the case at the ports: `par_q` must show the value the chain has after that shift, not the value before it. The bench also checks that the late tap still carries the old last-stage bit between the serial rise and the serial fall.

// File: rtl/shift_store_pkg.sv
package shift_store_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_evt_t;
endpackage

// File: rtl/sclk_edge_det.sv
module sclk_edge_det
  import shift_store_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sclk,
  output sclk_evt_t evt
);
  logic sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk;
  end

  assign evt.rise = sclk & ~sclk_prev;
  assign evt.fall = ~sclk & sclk_prev;
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              sdata,
  output logic [STAGES-1:0] stages_q,
  output logic [STAGES-1:0] stages_d
);
  logic [STAGES-1:0] stage_in;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stage_in[g] = sdata;
    end else begin : g_body
      assign stage_in[g] = stages_q[g-1];
    end
  end

  assign stages_d = shift_en ? stage_in : stages_q;

  always_ff @(posedge clk) begin
    if (rst) stages_q <= '0;
    else     stages_q <= stages_d;
  end
endmodule

// File: rtl/store_bank.sv
module store_bank #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              oe,
  input  logic [STAGES-1:0] chain_next,
  output logic [STAGES-1:0] store_q,
  output logic [STAGES-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      en_q    <= '0;
    end else begin
      if (strobe) store_q <= chain_next;
      en_q <= {STAGES{oe}};
    end
  end
endmodule

// File: rtl/cascade_tap.sv
module cascade_tap (
  input  logic clk,
  input  logic rst,
  input  logic fall,
  input  logic last_stage,
  output logic late_q
);
  always_ff @(posedge clk) begin
    if (rst)       late_q <= 1'b0;
    else if (fall) late_q <= last_stage;
  end
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg
  import shift_store_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              strobe,
  input  logic              oe,
  output logic [STAGES-1:0] par_q,
  output logic [STAGES-1:0] par_en,
  output logic              casc_early,
  output logic              casc_late
);
  localparam int LAST = STAGES - 1;

  sclk_evt_t         evt;
  logic [STAGES-1:0] stages_q;
  logic [STAGES-1:0] stages_d;
  logic [STAGES-1:0] store_q;

  sclk_edge_det u_edge (
    .clk (clk),
    .rst (rst),
    .sclk(sclk),
    .evt (evt)
  );

  shift_chain #(.STAGES(STAGES)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .shift_en(evt.rise),
    .sdata   (sdata),
    .stages_q(stages_q),
    .stages_d(stages_d)
  );

  store_bank #(.STAGES(STAGES)) u_store (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .oe        (oe),
    .chain_next(stages_d),
    .store_q   (store_q),
    .en_q      (par_en)
  );

  cascade_tap u_late (
    .clk       (clk),
    .rst       (rst),
    .fall      (evt.fall),
    .last_stage(stages_q[LAST]),
    .late_q    (casc_late)
  );

  assign par_q      = store_q;
  assign casc_early = stages_q[LAST];
endmodule

// File: rtl/shift_store_chk.sv
module shift_store_chk #(
  parameter int STAGES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sdata,
  input logic              strobe,
  input logic              oe,
  input logic              rise,
  input logic              fall,
  input logic [STAGES-1:0] stages_q,
  input logic [STAGES-1:0] par_q,
  input logic [STAGES-1:0] par_en,
  input logic              casc_early,
  input logic              casc_late
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stages_q == '0 && par_q == '0 && par_en == '0 && !casc_late));

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    rise |=> stages_q == {$past(stages_q[STAGES-2:0]), $past(sdata)});

  p_follow_r3: assert property (@(posedge clk) disable iff (rst)
    strobe |=> par_q == stages_q);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(par_q));

  p_en_on_r5: assert property (@(posedge clk) disable iff (rst)
    oe |=> par_en == '1);

  p_en_off_r5: assert property (@(posedge clk) disable iff (rst)
    !oe |=> par_en == '0);

  p_early_r6: assert property (@(posedge clk) disable iff (rst)
    rise |=> casc_early == $past(stages_q[STAGES-2]));

  p_late_load_r7: assert property (@(posedge clk) disable iff (rst)
    fall |=> casc_late == $past(casc_early));

  p_late_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(casc_late));
endmodule

bind shift_store_reg shift_store_chk #(.STAGES(STAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sdata     (sdata),
  .strobe    (strobe),
  .oe        (oe),
  .rise      (evt.rise),
  .fall      (evt.fall),
  .stages_q  (stages_q),
  .par_q     (par_q),
  .par_en    (par_en),
  .casc_early(casc_early),
  .casc_late (casc_late)
);

// File: tb/shift_store_reg_tb_top.sv
module shift_store_reg_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, strobe = 1'b0, oe = 1'b0;
  logic [N-1:0] qa, ena, qb, enb;
  logic ea, la, eb, lb;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [2*N-1:0] model = '0;

  always #4 clk = ~clk;

  shift_store_reg #(.STAGES(N)) dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .strobe(strobe), .oe(oe),
    .par_q(qa), .par_en(ena), .casc_early(ea), .casc_late(la));

  shift_store_reg #(.STAGES(N)) dut_b_i (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(la), .strobe(strobe), .oe(oe),
    .par_q(qb), .par_en(enb), .casc_early(eb), .casc_late(lb));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One serial pulse: rise seen at the next posedge, fall two cycles later.
  task automatic pulse(input logic b, input bit tap_checks);
    logic old_last;
    old_last = model[N-1];
    @(negedge clk);
    sdata = b;
    sclk  = 1'b1;
    model = {model[2*N-2:0], b};
    @(negedge clk);
    if (tap_checks) begin
      chk("R6 early tap after rise", {31'd0, ea}, {31'd0, model[N-1]});
      chk("R7 late tap holds until fall", {31'd0, la}, {31'd0, old_last});
    end
    @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
    if (tap_checks)
      chk("R7 late tap after fall", {31'd0, la}, {31'd0, model[N-1]});
  endtask

  task automatic strobe_once();
    @(negedge clk);
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset par_q", {24'd0, qa}, 32'd0);
    chk("R1 reset par_en", {24'd0, ena}, 32'd0);
    chk("R1 reset taps", {30'd0, ea, la}, 32'd0);

    // R9 + R4: 16 bits with strobe low, storage must hold, then strobe.
    pat = 16'hA5C3;
    for (int i = 15; i >= 0; i--) pulse(pat[i], 1'b1);
    chk("R4 storage holds while strobe low", {24'd0, qa}, 32'd0);
    strobe_once();
    chk("R9 first copy low byte", {24'd0, qa}, {24'd0, pat[7:0]});
    chk("R9 second copy high byte", {24'd0, qb}, {24'd0, pat[15:8]});

    // R5 + R8: enable toggles, shifting continues with oe low.
    @(negedge clk); oe = 1'b1;
    @(negedge clk);
    chk("R5 par_en all ones", {24'd0, ena}, 32'h0000_00FF);
    chk("R5 par_q visible", {24'd0, qa}, {24'd0, pat[7:0]});
    oe = 1'b0;
    @(negedge clk);
    chk("R5 par_en all zeros", {24'd0, ena}, 32'd0);
    pat = 16'h1E69;
    for (int i = 15; i >= 0; i--) pulse(pat[i], 1'b1);
    chk("R8 storage untouched by oe", {24'd0, qa}, {24'hA5C3 >> 16, 8'hC3} & 32'hFF);
    strobe_once();
    chk("R8 shifting with oe low, copy A", {24'd0, qa}, {24'd0, pat[7:0]});
    chk("R9 shifting with oe low, copy B", {24'd0, qb}, {24'd0, pat[15:8]});

    // R3 same-cycle shift and strobe: storage takes post-shift value.
    @(negedge clk);
    sdata  = 1'b1;
    sclk   = 1'b1;
    strobe = 1'b1;
    model  = {model[2*N-2:0], 1'b1};
    @(negedge clk);
    strobe = 1'b0;
    chk("R3 same-cycle shift and strobe", {24'd0, qa}, {24'd0, model[N-1:0]});
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
    pulse(1'b0, 1'b0);
    chk("R4 hold after strobe drop", {24'd0, qa}, {24'd0, model[N:1]});

    // R2 + R3 sweep: every byte shifted in with storage transparent.
    @(negedge clk); strobe = 1'b1;
    for (int v = 0; v < 256; v++) begin
      for (int i = N - 1; i >= 0; i--) begin
        pulse(v[i], 1'b0);
        chk("R2 transparent shift step", {24'd0, qa}, {24'd0, model[N-1:0]});
      end
      chk("R3 byte sweep", {24'd0, qa}, v);
      chk("R6 early tap in sweep", {31'd0, ea}, {31'd0, v[N-1]});
    end

    // R1 mid-run reset.
    @(negedge clk); oe = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset par_q", {24'd0, qa}, 32'd0);
    chk("R1 mid-run reset par_en", {24'd0, ena}, 32'd0);
    chk("R1 mid-run reset taps", {30'd0, ea, la}, 32'd0);
    rst = 1'b0;
    model = '0;
    @(negedge clk);
    chk("R5 enable returns after reset", {24'd0, ena}, 32'h0000_00FF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule